// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block recovers asynchronous serial frames from a line that is sampled on a tick enable running at sixteen times the bit rate. While idle it watches for a high-to-low change of the line. When it sees one, it counts sample ticks through each bit period. Near the centre of every bit it takes three samples and decides the bit value by majority.

A frame is one start bit, eight or nine data bits sent least-significant first, and one stop bit. The receiver checks the start bit before it commits to a frame. It accumulates a noise indication whenever the three samples of any bit disagree. It reports a framing error when the stop bit reads low. When the stop bit is decided, the block presents the word together with both flags and pulses a one-clock valid strobe.

The three sample points sit at fixed positions in the bit. A frame whose bits run a few percent longer or shorter than nominal therefore still lands every sample inside the right bit.

Top module: `rxo_frame_rx`

## Requirements
- R1: Bit timing advances only on clock edges where `tick_en` is high; each bit period is 16 ticks, and clock edges with `tick_en` low change neither timing nor state.
- R2: The tick on which the falling edge is seen is tick 1 of the start bit; every bit is decided by majority over the line values sampled on its ticks 8, 9 and 10.
- R3: A start is recognised only while idle, on a tick where the line reads 0 after reading 1 on the previous tick; if the start bit's majority is 1, the receiver returns to idle with no valid pulse and leaves `rx_data`, `noise_err` and `frame_err` unchanged.
- R4: `mode9` is captured when the start is recognised (1 = nine data bits, 0 = eight); data bits arrive LSB first; in eight-bit mode the word is on `rx_data[7:0]` and `rx_data[8]` is 0.
- R5: `noise_err` is 1 for a completed frame if the three samples of its start bit, any data bit or its stop bit were not all equal, and 0 otherwise; a single disturbed sample does not change the decided bit value.
- R6: `frame_err` is 1 for a completed frame whose stop-bit majority is 0; the data word is still delivered.
- R7: `rx_valid` is high for exactly one clock, in the clock after the tick that carries the tenth-tick sample of the stop bit, once per completed frame.
- R8: `rx_data`, `noise_err` and `frame_err` change only together with an `rx_valid` pulse and hold their values between pulses.
- R9: Frames whose bit period is 16.5 ticks (slow) or 15.5 ticks (fast) are received with correct data and no noise or framing error, in both data widths.
- R10: Reset puts the receiver in idle, with `rx_valid`, `noise_err`, `frame_err` and `rx_data` at 0; the line counts as low until it is first sampled high.
- R11: A new start edge on the tick right after the stop bit is decided is recognised, so back-to-back frames are received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Sample tick, sixteen per bit period |
| rx_line | input | 1 | Serial line, idle high |
| mode9 | input | 1 | 1 selects nine data bits, 0 selects eight |
| rx_data | output | 9 | Last received word |
| rx_valid | output | 1 | One-clock strobe when a frame completes |
| noise_err | output | 1 | Sample disagreement seen in the last frame |
| frame_err | output | 1 | Stop bit of the last frame decided low |

## Verification
Several properties are checked on every cycle by the assertions. The tick count always stays within one bit period and freezes on clocks without a tick. A vote never happens without the two earlier samples of the same bit. No vote happens while idle. The valid strobe never lasts two clocks. The outputs never move outside a valid pulse, and in eight-bit mode the top data bit is zero. Only the bench's scenarios can show the rest: the actual data values, the slow and fast timing margins, which glitch positions count as noise and which do not, the abandoned starts, the mode latch across a mid-frame change, and recovery from a reset in mid-frame.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/rxo_bit_timer.sv
module rxo_bit_timer #(
    parameter int OSR   = 16,
    parameter int CNT_W = $clog2(OSR + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic restart,
    input  logic run,
    output logic samp_stb,
    output logic vote_stb
);

    localparam logic [CNT_W-1:0] OSR_C   = CNT_W'(OSR);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
    localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(OSR / 2);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(OSR / 2 + 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t             tmr_d, tmr_q;
    logic [CNT_W-1:0] cur;

    always_comb begin
        tmr_d = tmr_q;
        cur   = (tmr_q.cnt >= OSR_C) ? ONE_C : tmr_q.cnt + ONE_C;
        if (restart && tick_en) begin
            tmr_d.cnt = ONE_C;
        end else if (!run) begin
            tmr_d.cnt = '0;
        end else if (tick_en) begin
            tmr_d.cnt = cur;
        end
        samp_stb = run && tick_en && (cur >= FIRST_C) && (cur <= LAST_C);
        vote_stb = run && tick_en && (cur == LAST_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= OSR_C); // R1

    AST_TICK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick_en && !restart) |=> $stable(tmr_q.cnt)); // R1

endmodule

// File: rtl/rxo_vote.sv
module rxo_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic samp_stb,
    input  logic vote_stb,
    input  logic line,
    output logic bit_val,
    output logic bit_noisy
);

    typedef struct packed {
        logic [1:0] smp;
        logic [1:0] n;
    } vote_t;

    vote_t vt_d, vt_q;

    always_comb begin
        vt_d = vt_q;
        if (clear || vote_stb) begin
            vt_d.n = 2'd0;
        end else if (samp_stb) begin
            vt_d.smp = {vt_q.smp[0], line};
            vt_d.n   = vt_q.n + 2'd1;
        end
        bit_val   = (vt_q.smp[1] & vt_q.smp[0]) |
                    (vt_q.smp[1] & line) |
                    (vt_q.smp[0] & line);
        bit_noisy = !((vt_q.smp[1] == vt_q.smp[0]) && (vt_q.smp[0] == line));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vt_q <= '0;
        end else begin
            vt_q <= vt_d;
        end
    end

    AST_THREE_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        vote_stb |-> (vt_q.n == 2'd2)); // R2

    AST_NO_EXTRA_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_stb && !vote_stb) |-> (vt_q.n < 2'd2)); // R2

endmodule

// File: rtl/rxo_frame_rx.sv
module rxo_frame_rx
    import rxo_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          rx_line,
    input  logic          mode9,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          noise_err,
    output logic          frame_err
);

    localparam int              BW         = $clog2(DW);
    localparam logic [BW-1:0]   LAST_LONG  = BW'(DW - 1);
    localparam logic [BW-1:0]   LAST_SHORT = BW'(DW - 2);

    typedef struct packed {
        rx_state_e      st;
        logic           line;
        logic           mode;
        logic [BW-1:0]  bidx;
        logic [DW-1:0]  shreg;
        logic           nacc;
        logic [DW-1:0]  data;
        logic           valid;
        logic           noise;
        logic           frame;
    } rx_regs_t;

    rx_regs_t      rx_d, rx_q;
    logic          restart;
    logic          samp_stb;
    logic          vote_stb;
    logic          bit_val;
    logic          bit_noisy;
    logic [BW-1:0] last_idx;

    rxo_bit_timer #(.OSR(OSR)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .restart  (restart),
        .run      (rx_q.st != ST_IDLE),
        .samp_stb (samp_stb),
        .vote_stb (vote_stb)
    );

    rxo_vote u_vote (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (restart),
        .samp_stb  (samp_stb),
        .vote_stb  (vote_stb),
        .line      (rx_line),
        .bit_val   (bit_val),
        .bit_noisy (bit_noisy)
    );

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        restart    = (rx_q.st == ST_IDLE) && tick_en && rx_q.line && !rx_line;
        last_idx   = rx_q.mode ? LAST_LONG : LAST_SHORT;
        if (tick_en) begin
            rx_d.line = rx_line;
        end
        case (rx_q.st)
            ST_IDLE: begin
                if (restart) begin
                    rx_d.st   = ST_START;
                    rx_d.mode = mode9;
                    rx_d.bidx = '0;
                    rx_d.nacc = 1'b0;
                end
            end
            ST_START: begin
                if (vote_stb) begin
                    if (bit_val) begin
                        rx_d.st = ST_IDLE;
                    end else begin
                        rx_d.st   = ST_DATA;
                        rx_d.nacc = bit_noisy;
                    end
                end
            end
            ST_DATA: begin
                if (vote_stb) begin
                    rx_d.shreg = {bit_val, rx_q.shreg[DW-1:1]};
                    rx_d.nacc  = rx_q.nacc | bit_noisy;
                    if (rx_q.bidx == last_idx) begin
                        rx_d.st = ST_STOP;
                    end else begin
                        rx_d.bidx = rx_q.bidx + BW'(1);
                    end
                end
            end
            ST_STOP: begin
                if (vote_stb) begin
                    rx_d.st    = ST_IDLE;
                    rx_d.valid = 1'b1;
                    rx_d.noise = rx_q.nacc | bit_noisy;
                    rx_d.frame = !bit_val;
                    rx_d.data  = rx_q.mode ? rx_q.shreg
                                           : {1'b0, rx_q.shreg[DW-1:1]};
                end
            end
            default: rx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_data   = rx_q.data;
    assign rx_valid  = rx_q.valid;
    assign noise_err = rx_q.noise;
    assign frame_err = rx_q.frame;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(noise_err) && $stable(frame_err))); // R8

    AST_SHORT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_q.mode) |-> (rx_data[DW-1] == 1'b0)); // R4

    AST_IDLE_NO_VOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.st == ST_IDLE) |-> !vote_stb); // R3

endmodule

// File: tb/tb_rxo_frame_rx.sv
`timescale 1ns/1ps
module tb_rxo_frame_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       rx_line = 1'b1;
    logic       mode9 = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       noise_err;
    logic       frame_err;

    int total = 0;
    int bad = 0;
    int vcnt = 0;
    int dbl = 0;
    int tcnt = 0;
    int cyc = 0;
    logic prev_valid = 1'b0;

    always #2.5 clk = ~clk;

    rxo_frame_rx dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .rx_line   (rx_line),
        .mode9     (mode9),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .noise_err (noise_err),
        .frame_err (frame_err)
    );

    typedef struct packed {
        logic       m9;
        logic [8:0] data;
        logic [5:0] l2;      // bit length in half ticks
        logic [7:0] glitch;  // tick to invert, 0 = none
        logic       stopv;
        logic [3:0] gap;
        logic       flipm;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 9'h0A5, 6'd32, 8'd0,   1'b1, 4'd4, 1'b0},
        '{1'b1, 9'h1C3, 6'd32, 8'd0,   1'b1, 4'd4, 1'b0},
        '{1'b0, 9'h0FF, 6'd33, 8'd0,   1'b1, 4'd0, 1'b0},
        '{1'b0, 9'h000, 6'd31, 8'd0,   1'b1, 4'd3, 1'b0},
        '{1'b1, 9'h155, 6'd33, 8'd0,   1'b1, 4'd0, 1'b0},
        '{1'b1, 9'h0AA, 6'd31, 8'd0,   1'b1, 4'd3, 1'b0},
        '{1'b0, 9'h03C, 6'd32, 8'd56,  1'b1, 4'd3, 1'b0},
        '{1'b0, 9'h081, 6'd32, 8'd8,   1'b1, 4'd3, 1'b0},
        '{1'b0, 9'h07E, 6'd32, 8'd153, 1'b1, 4'd3, 1'b0},
        '{1'b0, 9'h012, 6'd32, 8'd0,   1'b0, 4'd4, 1'b0},
        '{1'b1, 9'h1FF, 6'd32, 8'd0,   1'b0, 4'd4, 1'b0},
        '{1'b1, 9'h0F0, 6'd32, 8'd50,  1'b1, 4'd3, 1'b0},
        '{1'b1, 9'h101, 6'd32, 8'd0,   1'b1, 4'd3, 1'b1},
        '{1'b0, 9'h0C7, 6'd32, 8'd0,   1'b1, 4'd3, 1'b1},
        '{1'b1, 9'h1AB, 6'd32, 8'd167, 1'b1, 4'd2, 1'b0}
    };

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) vcnt++;
            if (rx_valid && prev_valid) dbl++;
            prev_valid <= rx_valid;
        end else begin
            prev_valid <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_tick(input logic v);
        @(negedge clk);
        rx_line = v;
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        repeat (tcnt % 3) @(negedge clk);
        tcnt++;
    endtask

    task automatic send_frame(input logic m9, input logic [8:0] data, input int l2,
                              input int glitch, input logic stopv, input int gap,
                              input logic flipm);
        int   nb;
        int   tot;
        int   idx;
        logic b;
        nb  = m9 ? 9 : 8;
        tot = ((nb + 2) * l2 + 1) / 2;
        mode9 = m9;
        for (int t = 0; t < tot; t++) begin
            idx = (2 * t) / l2;
            if (idx == 0)            b = 1'b0;
            else if (idx <= nb)      b = data[idx-1];
            else if (idx == nb + 1)  b = stopv;
            else                     b = 1'b1;
            if (glitch != 0 && t == glitch) b = ~b;
            if (flipm && t == 20) mode9 = ~mode9;
            do_tick(b);
        end
        for (int g = 0; g < gap; g++) do_tick(1'b1);
    endtask

    initial begin
        int   base;
        logic [8:0] sd;
        logic sn;
        logic sf;

        // reset state, R10
        repeat (4) @(negedge clk);
        check("R10 data", 32'(rx_data), 0);
        check("R10 valid", 32'(rx_valid), 0);
        check("R10 noise", 32'(noise_err), 0);
        check("R10 frame", 32'(frame_err), 0);
        rst_n = 1'b1;
        do_tick(1'b1);
        do_tick(1'b1);

        // table of frames: R2 R4 R5 R6 R9 R11
        for (int i = 0; i < NV; i++) begin
            vec_t       v;
            logic [8:0] ed;
            logic       en;
            int         g;
            string      rq;
            v    = VEC[i];
            g    = int'(v.glitch);
            ed   = v.m9 ? v.data : {1'b0, v.data[7:0]};
            en   = (g != 0) && ((g % 16) >= 7) && ((g % 16) <= 9);
            rq   = (v.l2 != 6'd32) ? "R9" : (v.flipm ? "R4 mode latch" : "R4");
            base = vcnt;
            send_frame(v.m9, v.data, int'(v.l2), g, v.stopv, int'(v.gap), v.flipm);
            @(negedge clk);
            check("R7 one valid per frame", 32'(vcnt - base), 1);
            check(rq, 32'(rx_data), 32'(ed));
            check("R5 noise", 32'(noise_err), 32'(en));
            check("R6 frame", 32'(frame_err), 32'(!v.stopv));
        end

        // R3: short low pulse, start majority reads 1
        sd = rx_data; sn = noise_err; sf = frame_err; base = vcnt;
        do_tick(1'b0); do_tick(1'b0);
        for (int k = 0; k < 40; k++) do_tick(1'b1);
        check("R3 no valid short", 32'(vcnt - base), 0);
        check("R3 data kept", 32'(rx_data), 32'(sd));
        check("R3 flags kept", 32'({noise_err, frame_err}), 32'({sn, sf}));

        // R3: low through tick 8 only, two of three start samples high
        for (int k = 0; k < 8; k++) do_tick(1'b0);
        for (int k = 0; k < 40; k++) do_tick(1'b1);
        check("R3 no valid edge case", 32'(vcnt - base), 0);
        check("R3 flags kept 2", 32'({noise_err, frame_err}), 32'({sn, sf}));

        // R1: line toggles without ticks
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            rx_line = k[0];
        end
        rx_line = 1'b1;
        check("R1 no tick no valid", 32'(vcnt - base), 0);
        check("R1 data kept", 32'(rx_data), 32'(sd));
        send_frame(1'b0, 9'h05A, 32, 0, 1'b1, 3, 1'b0);
        @(negedge clk);
        check("R1 frame after idle toggling", 32'(rx_data), 32'h05A);

        // R10: reset in mid-frame
        base = vcnt;
        mode9 = 1'b1;
        do_tick(1'b0);
        for (int k = 0; k < 60; k++) do_tick(k[2]);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid reset data", 32'(rx_data), 0);
        check("R10 mid reset flags", 32'({noise_err, frame_err, rx_valid}), 0);
        rst_n = 1'b1;
        do_tick(1'b1);
        do_tick(1'b1);
        send_frame(1'b1, 9'h1E1, 32, 0, 1'b1, 3, 1'b0);
        @(negedge clk);
        check("R10 recovery data", 32'(rx_data), 32'h1E1);
        check("R10 recovery count", 32'(vcnt - base), 1);

        // R7: never two-clock valid
        check("R7 pulse width", 32'(dbl), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule